// File: doc/BRIEF.md
# ECC Sector Status Aggregator

While a flash page is read, an error-correction decoder processes the page one 512-byte sector at a time. After each sector it reports a completion strobe, the sector index, the number of bits it corrected and whether correction failed. This block turns that stream of reports into one summary status word for the page. It also keeps a sticky error flag that software clears, and drives an interrupt line from that flag.

The summary word keeps three things:
- a failed flag for each sector;
- a corrected flag for each sector;
- the largest corrected-bit count seen in any sector that did not fail.

A new page read is announced with `page_start`. That pulse clears the per-page summary. It does not clear the sticky error flag, which software clears by writing one to it; the `err_clr` strobe stands for that write. The page size is a parameter, and the sector count is the page size divided by 512.

Top module: `ecc_sector_summary`

## Requirements
- R1: After reset, `status_word`, `err_status` and `irq` are all zero.
- R2: A report with `sec_fail` high on an in-range sector n sets `status_word[24+n]` on the next clock edge. It does not set that sector's corrected flag.
- R3: A report with `sec_fail` low and a nonzero `sec_cnt` sets `status_word[16+n]` on the next edge. A report with a zero count and no failure sets no flag.
- R4: `status_word[12:8]` holds the largest `sec_cnt` reported by non-failed sectors since the last page start. Bits 15:13 and 7:0 always read zero.
- R5: `err_status` goes high on the edge after an accepted report that either failed or carried a nonzero count. A page whose sectors all report zero and no failure leaves it low.
- R6: `err_clr` clears `err_status` on the next edge. If a new error report arrives in the same cycle, the set wins.
- R7: `irq` equals `err_status` AND `err_ie` AND `glb_ie` in every cycle.
- R8: `page_start` zeroes all flags and the maximum count on the next edge. A sector report in that same cycle is discarded. `err_status` is not affected.
- R9: A report whose `sec_idx` is at or above PAGE_BYTES/512 is ignored entirely; with the default of 2048 bytes, that is indices 4 to 7.
- R10: While `sec_done` is low, `sec_idx`, `sec_cnt` and `sec_fail` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| page_start | input | 1 | Pulse at the start of a page read |
| sec_done | input | 1 | Decoder has finished one sector |
| sec_idx | input | 3 | Index of the reported sector |
| sec_cnt | input | 5 | Corrected-bit count for the sector |
| sec_fail | input | 1 | Sector could not be corrected |
| err_clr | input | 1 | Write-one-to-clear of the error flag |
| err_ie | input | 1 | Error interrupt enable |
| glb_ie | input | 1 | Global interrupt enable |
| status_word | output | 32 | {failed[7:0], corrected[7:0], 3'b0, max count, 8'b0} |
| err_status | output | 1 | Sticky error flag |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situations to reach are the coincidences:
- a clear that lands in the same cycle as a new error report;
- a page start that lands on a sector report.

Both depend on a one-cycle alignment that ordinary page traffic rarely produces. Directed phases place these strobes together on purpose. Out-of-range indices are also driven while `sec_fail` is high, so that an ignored report would be visible if it leaked through. A long random phase then mixes all the strobes densely, and a behavioural model is compared against the outputs on every cycle.

// File: rtl/ecc_sector_summary.sv
module ecc_sector_summary #(
  parameter int PAGE_BYTES = 2048,
  parameter int STEP_BYTES = 512,
  parameter int SLOTS      = 8,
  parameter int CNT_W      = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        page_start,
  input  logic        sec_done,
  input  logic [2:0]  sec_idx,
  input  logic [4:0]  sec_cnt,
  input  logic        sec_fail,
  input  logic        err_clr,
  input  logic        err_ie,
  input  logic        glb_ie,
  output logic [31:0] status_word,
  output logic        err_status,
  output logic        irq
);
  localparam int NSEC = PAGE_BYTES / STEP_BYTES;

  logic [SLOTS-1:0] fail_q, corr_q;
  logic [CNT_W-1:0] max_q;
  logic             err_q;

  wire in_range = int'(sec_idx) < NSEC;
  wire rpt_ok   = sec_done && !page_start && in_range;
  wire rpt_err  = rpt_ok && (sec_fail || sec_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_q <= '0;
      corr_q <= '0;
      max_q  <= '0;
    end else if (page_start) begin
      fail_q <= '0;
      corr_q <= '0;
      max_q  <= '0;
    end else if (rpt_ok) begin
      if (sec_fail) begin
        fail_q[sec_idx] <= 1'b1;
      end else begin
        if (sec_cnt != '0) corr_q[sec_idx] <= 1'b1;
        if (sec_cnt > max_q) max_q <= sec_cnt;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       err_q <= 1'b0;
    else if (rpt_err) err_q <= 1'b1;
    else if (err_clr) err_q <= 1'b0;
  end

  assign status_word = {fail_q, corr_q, 3'b000, max_q, 8'h00};
  assign err_status  = err_q;
  assign irq         = err_q & err_ie & glb_ie;
endmodule

module ecc_sector_summary_chk #(
  parameter int NSEC = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        page_start,
  input logic        sec_done,
  input logic [2:0]  sec_idx,
  input logic [4:0]  sec_cnt,
  input logic        sec_fail,
  input logic        err_clr,
  input logic [31:0] status_word,
  input logic        err_status
);
  wire ok  = sec_done && !page_start && (int'(sec_idx) < NSEC);
  wire bad = ok && (sec_fail || sec_cnt != 5'd0);

  a_r2_fail_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ok && sec_fail |=> status_word[24 + $past(sec_idx)]);
  a_r4_max_grows: assert property (@(posedge clk) disable iff (!rst_n)
    !page_start |=> status_word[12:8] >= $past(status_word[12:8]));
  a_r5_err_set: assert property (@(posedge clk) disable iff (!rst_n)
    bad |=> err_status);
  a_r6_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr && !bad |=> !err_status);
  a_r8_page_clear: assert property (@(posedge clk) disable iff (!rst_n)
    page_start |=> status_word == 32'd0);
  a_r9_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
    sec_done && !page_start && int'(sec_idx) >= NSEC |=> $stable(status_word));
endmodule

bind ecc_sector_summary ecc_sector_summary_chk #(.NSEC(PAGE_BYTES / STEP_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .page_start(page_start), .sec_done(sec_done),
  .sec_idx(sec_idx), .sec_cnt(sec_cnt), .sec_fail(sec_fail), .err_clr(err_clr),
  .status_word(status_word), .err_status(err_status)
);

// File: tb/ecc_sector_summary_test.sv
`timescale 1ns/1ps
module ecc_sector_summary_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic page_start = 0, sec_done = 0, sec_fail = 0, err_clr = 0, err_ie = 0, glb_ie = 0;
  logic [2:0] sec_idx = 0;
  logic [4:0] sec_cnt = 0;
  logic [31:0] status_word;
  logic err_status, irq;

  always #4 clk = ~clk;

  ecc_sector_summary uut (.*);

  int compared = 0, mismatched = 0, cycles = 0;
  bit m_fail[8], m_corr[8];
  int m_max = 0;
  bit m_err = 0;
  bit running = 0;

  task automatic chk(string tag, longint act, longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // Reference model: acts on the inputs seen at each rising edge
  always @(posedge clk) if (rst_n) begin
    bit ok, bad;
    ok  = sec_done && !page_start && sec_idx < 4;
    bad = ok && (sec_fail || sec_cnt != 0);
    if (page_start) begin
      foreach (m_fail[i]) begin m_fail[i] = 0; m_corr[i] = 0; end
      m_max = 0;
    end else if (ok) begin
      if (sec_fail) m_fail[sec_idx] = 1;
      else begin
        if (sec_cnt != 0) m_corr[sec_idx] = 1;
        if (sec_cnt > m_max) m_max = sec_cnt;
      end
    end
    if (bad) m_err = 1;
    else if (err_clr) m_err = 0;
  end

  function automatic logic [31:0] m_word();
    logic [31:0] w = 0;
    for (int i = 0; i < 8; i++) begin
      w[24+i] = m_fail[i];
      w[16+i] = m_corr[i];
    end
    w[12:8] = m_max[4:0];
    return w;
  endfunction

  always @(negedge clk) if (running) begin
    logic [31:0] e;
    cycles++;
    e = m_word();
    chk("R2 failed flags", status_word[31:24], e[31:24]);
    chk("R3 corrected flags", status_word[23:16], e[23:16]);
    chk("R4 max count and zero bits", {status_word[15:0]}, {e[15:0]});
    chk("R5/R6 err_status", err_status, m_err);
    chk("R7 irq", irq, m_err & err_ie & glb_ie);
  end

  task automatic idle();
    page_start = 0; sec_done = 0; err_clr = 0;
  endtask

  task automatic cyc();
    @(negedge clk); #1;
  endtask

  task automatic rpt(input int idx, input int cnt, input bit f);
    idle(); sec_done = 1; sec_idx = idx[2:0]; sec_cnt = cnt[4:0]; sec_fail = f; cyc();
  endtask

  task automatic start_page();
    idle(); page_start = 1; cyc();
  endtask

  task automatic clear_err();
    idle(); err_clr = 1; cyc();
  endtask

  initial begin
    #1;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1 status_word", status_word, 0);
    chk("R1 err_status", err_status, 0);
    chk("R1 irq", irq, 0);
    #1 rst_n = 1; running = 1;
    @(negedge clk); #1;
    // R3 R4 R5: corrected sectors with counts 3 7 0 2
    err_ie = 1; glb_ie = 1;
    start_page();
    rpt(0, 3, 0); rpt(1, 7, 0); rpt(2, 0, 0); rpt(3, 2, 0); idle(); cyc();
    // R2: failure on sector 2 with nonzero count
    rpt(2, 30, 1); idle(); cyc();
    // R6: clear
    clear_err(); idle(); cyc();
    // R5: clean page leaves error clear
    start_page(); rpt(0, 0, 0); rpt(1, 0, 0); rpt(2, 0, 0); rpt(3, 0, 0); idle(); cyc();
    // R9: out-of-range indices ignored
    rpt(5, 9, 1); rpt(4, 12, 0); rpt(7, 1, 0); idle(); cyc();
    // R10: strobe low, other inputs active
    idle(); sec_idx = 1; sec_cnt = 20; sec_fail = 1; cyc(); cyc();
    // R6: set and clear together, set wins
    rpt(1, 4, 0); clear_err();
    idle(); sec_done = 1; sec_idx = 3; sec_cnt = 5; sec_fail = 0; err_clr = 1; cyc();
    idle(); cyc();
    // R8: page start coincides with a report
    idle(); page_start = 1; sec_done = 1; sec_idx = 0; sec_cnt = 31; sec_fail = 1; cyc();
    idle(); cyc();
    // R7: enable combinations
    rpt(0, 1, 0);
    for (int k = 0; k < 4; k++) begin
      err_ie = k[0]; glb_ie = k[1]; idle(); cyc();
    end
    // Random phase
    for (int n = 0; n < 3000; n++) begin
      idle();
      page_start = ($urandom % 40) == 0;
      sec_done   = $urandom % 2;
      sec_idx    = 3'($urandom);
      sec_cnt    = 5'($urandom);
      sec_fail   = ($urandom % 4) == 0;
      err_clr    = ($urandom % 8) == 0;
      if (($urandom % 16) == 0) err_ie = ~err_ie;
      if (($urandom % 16) == 0) glb_ie = ~glb_ie;
      cyc();
    end
    idle(); cyc();
    running = 0;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #400000;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule